// File: doc/BRIEF.md
# Sync Polarity Normalizing Composite Combiner

The block takes separate horizontal and vertical sync signals and merges them into one composite sync. Neither input polarity is known in advance, because it can be active-high or active-low depending on the display mode. So each input has its own detector. The detector watches the input over a window much longer than a line period and takes the majority level as the idle level.

Each synchronized input is exclusive-ORed with its idle level. This turns every active pulse into a logic 1, whatever the input polarity. The two normalized signals are then exclusive-ORed together. As a result, while vertical sync is active the horizontal pulses keep arriving at the line rate, but as low-going notches in a high level. A final exclusive-OR with a select input sets the polarity of the composite.

All logic runs on one sampling clock. The composite is registered, so every input edge reaches it after the same fixed delay.

Top module: `sync_combiner`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `csync` is 0, `h_act_low` and `v_act_low` are 1 (active-low assumed), and `det_valid` is 0.
- R2: Each input has a saturating counter that starts at 2^(CNT_W-1). The counter goes up on each cycle the synchronized input is 1 and down on each cycle it is 0. The detector marks the input active-low (flag 1) when the counter is at or above CMAX-CMAX/4, where CMAX = 2^CNT_W-1. It marks the input active-high (flag 0) when the counter is at or below CMAX/4. Between those two thresholds the flag keeps its previous value.
- R3: Each synchronized input is exclusive-ORed with its flag, so an active sync pulse becomes 1 and its idle level becomes 0.
- R4: The combined value is the exclusive-OR of the two normalized signals. While vertical sync is active, horizontal pulses therefore appear in the composite as 0 against a level of 1.
- R5: With `pol_inv` at 0 the combined value reaches `csync` unchanged. With `pol_inv` at 1 it is inverted.
- R6: An edge on either sync input reaches `csync` exactly three rising clock edges later: two synchronizer stages plus the output register.
- R7: A per-input settled bit sets once that input's counter first reaches either threshold, and it then stays set until reset. `det_valid` is the AND of the two settled bits.
- R8: The counters saturate at 0 and at CMAX and never wrap. A long constant input therefore cannot flip a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, either polarity, asynchronous |
| vsync_in | input | 1 | Vertical sync, either polarity, asynchronous |
| pol_inv | input | 1 | Composite polarity select, 1 inverts |
| csync | output | 1 | Registered composite sync |
| h_act_low | output | 1 | Horizontal input detected active-low |
| v_act_low | output | 1 | Vertical input detected active-low |
| det_valid | output | 1 | Both detectors have settled |

## Verification
The bench first drives both syncs active-low and then both active-high. This exercises both hysteresis thresholds and both flag transitions. A design that inverts the wrong way would show the wrong flags, and a merge by AND or OR would show the wrong composite. A vertical pulse that overlaps several line pulses must produce low notches in the composite; a design that holds the output flat for the whole vertical interval misses these.

Long stretches of a constant input drive the counters into saturation. A counter that wraps instead of saturating would flip its flag during these stretches. Both sync inputs are also toggled in a fixed cycle relative to the clock to measure the input-to-output delay of each path. A mismatch between the two paths would show up as glitches in the composite. Finally, `pol_inv` is changed mid-stream to catch a select that is ignored or applied on the wrong path.

// File: rtl/sync_combiner.sv
module sync_combiner #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic pol_inv,
  output logic csync,
  output logic h_act_low,
  output logic v_act_low,
  output logic det_valid
);
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int HI_TH = CMAX - CMAX / 4;
  localparam int LO_TH = CMAX / 4;
  localparam logic [CNT_W-1:0] MID = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] TOP = CNT_W'(CMAX);

  logic [1:0] h_sy, v_sy;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic h_set, v_set, run_q;
  logic h_norm, v_norm, comp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_sy <= '0;
      v_sy <= '0;
    end else begin
      h_sy <= {h_sy[0], hsync_in};
      v_sy <= {v_sy[0], vsync_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= MID;
      h_act_low <= 1'b1;
      h_set <= 1'b0;
    end else begin
      if (h_sy[1] && h_cnt != TOP) h_cnt <= h_cnt + 1'b1;
      else if (!h_sy[1] && h_cnt != '0) h_cnt <= h_cnt - 1'b1;
      if (int'(h_cnt) >= HI_TH) begin
        h_act_low <= 1'b1;
        h_set <= 1'b1;
      end else if (int'(h_cnt) <= LO_TH) begin
        h_act_low <= 1'b0;
        h_set <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_cnt <= MID;
      v_act_low <= 1'b1;
      v_set <= 1'b0;
    end else begin
      if (v_sy[1] && v_cnt != TOP) v_cnt <= v_cnt + 1'b1;
      else if (!v_sy[1] && v_cnt != '0) v_cnt <= v_cnt - 1'b1;
      if (int'(v_cnt) >= HI_TH) begin
        v_act_low <= 1'b1;
        v_set <= 1'b1;
      end else if (int'(v_cnt) <= LO_TH) begin
        v_act_low <= 1'b0;
        v_set <= 1'b1;
      end
    end
  end

  assign h_norm = h_sy[1] ^ h_act_low;
  assign v_norm = v_sy[1] ^ v_act_low;
  assign comp = h_norm ^ v_norm;
  assign det_valid = h_set & v_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csync <= 1'b0;
      run_q <= 1'b0;
    end else begin
      csync <= comp ^ pol_inv;
      run_q <= 1'b1;
    end
  end

  assert_sat_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == TOP && h_sy[1]) |=> (h_cnt == TOP));
  assert_sat_bot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt == '0 && !v_sy[1]) |=> (v_cnt == '0));
  assert_hyst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$stable(h_act_low)) |-> (int'($past(h_cnt)) >= HI_TH || int'($past(h_cnt)) <= LO_TH));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> det_valid);
  assert_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !$stable(pol_inv) && $stable(comp)) |=> (csync != $past(csync)));
endmodule

// File: tb/tb_sync_combiner.sv
module tb_sync_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int CMAX = (1 << W) - 1;
  localparam int HI = CMAX - CMAX / 4;
  localparam int LO = CMAX / 4;

  logic clk = 0, rst_n = 0, hsync_in = 0, vsync_in = 0, pol_inv = 0;
  logic csync, h_act_low, v_act_low, det_valid;
  int tests = 0, fails = 0;

  sync_combiner #(.CNT_W(W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit hq[$], vq[$];
  int hc, vc;
  bit hf, vf, hs, vs, m_cs;

  task automatic chk(input string req, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hq.delete(); vq.delete();
      hc = 1 << (W-1); vc = hc; hf = 1; vf = 1; hs = 0; vs = 0; m_cs = 0;
    end else begin
      bit h2, v2;
      h2 = (hq.size() == 2) ? hq[0] : 0;
      v2 = (vq.size() == 2) ? vq[0] : 0;
      m_cs = (h2 ^ hf) ^ (v2 ^ vf) ^ pol_inv;
      if (hc >= HI) begin hf = 1; hs = 1; end else if (hc <= LO) begin hf = 0; hs = 1; end
      if (vc >= HI) begin vf = 1; vs = 1; end else if (vc <= LO) begin vf = 0; vs = 1; end
      hc = h2 ? (hc < CMAX ? hc + 1 : hc) : (hc > 0 ? hc - 1 : 0);
      vc = v2 ? (vc < CMAX ? vc + 1 : vc) : (vc > 0 ? vc - 1 : 0);
      hq.push_back(hsync_in); vq.push_back(vsync_in);
      if (hq.size() > 2) void'(hq.pop_front());
      if (vq.size() > 2) void'(vq.pop_front());
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    chk("R3/R4/R6 csync", csync, m_cs);
    chk("R2/R8 h_act_low", h_act_low, hf);
    chk("R2/R8 v_act_low", v_act_low, vf);
    chk("R7 det_valid", det_valid, hs & vs);
  end

  // stimulus: hp/vp are active levels
  int ph = 0, pv = 0, vfalls = 0, vwin = 0;
  bit prev_cs = 0;
  task automatic run(input int n, input bit hp, input bit vp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync_in = (ph % 16 < 2) ? hp : ~hp;
      vsync_in = (pv % 200 < 40) ? vp : ~vp;
      if (vwin && prev_cs && !csync) vfalls++;
      prev_cs = csync;
      ph++; pv++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    hsync_in = 1; vsync_in = 1;
    repeat (4) @(negedge clk);
    chk("R1 csync reset", csync, 0);
    chk("R1 h_act_low reset", h_act_low, 1);
    chk("R1 v_act_low reset", v_act_low, 1);
    chk("R1 det_valid reset", det_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 det_valid after reset", det_valid, 0);
    cmp_on = 1;
    pv = 40;
    run(400, 0, 0);
    chk("R7 settled active-low", det_valid, 1);
    chk("R2 h active-low", h_act_low, 1);
    // R4: notches during a vertical pulse
    pv = 0; vwin = 1; vfalls = 0;
    run(40, 0, 0);
    vwin = 0;
    tests++;
    if (vfalls < 2) begin fails++; $display("FAIL R4 notches actual=%0d expected>=2", vfalls); end
    run(200, 0, 0);
    // R5 polarity select
    pol_inv = 1;
    run(300, 0, 0);
    pol_inv = 0;
    // R2: switch to active-high
    run(600, 1, 1);
    chk("R2 h active-high", h_act_low, 0);
    chk("R2 v active-high", v_act_low, 0);
    chk("R7 sticky", det_valid, 1);
    // R8 saturation at 0: hold both low
    @(negedge clk); hsync_in = 0; vsync_in = 0;
    repeat (300) @(negedge clk);
    chk("R8 h no wrap", h_act_low, 0);
    chk("R8 v no wrap", v_act_low, 0);
    chk("R3 idle composite", csync, 0);
    // R6 latency, H path then V path
    hsync_in = 1;
    @(posedge clk); @(posedge clk); #1 chk("R6 h not early", csync, 0);
    @(posedge clk); #1 chk("R6 h edge at 3", csync, 1);
    @(negedge clk); hsync_in = 0;
    repeat (4) @(negedge clk);
    vsync_in = 1;
    @(posedge clk); @(posedge clk); #1 chk("R6 v not early", csync, 0);
    @(posedge clk); #1 chk("R6 v edge at 3", csync, 1);
    @(negedge clk); vsync_in = 0;
    // R8 saturation at top
    hsync_in = 1; vsync_in = 1;
    repeat (300) @(negedge clk);
    chk("R8 h high", h_act_low, 1);
    run(300, 0, 0);
    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule